// File: doc/BRIEF.md
# SPI DMA Half-Word Byte Packer

This block bridges a DMA controller that moves 16-bit half-words and a serial shift engine that moves one byte at a time. On the transmit side it asks the DMA for half-words while its transmit queue has a free slot. It then hands the bytes of each half-word to the shifter, low byte first. On the receive side it pairs incoming bytes into half-words and asks the DMA to collect each completed half-word.

A programmed byte count N sets the length of a transfer. The block fetches and delivers ceil(N/2) half-words. When N is odd, the spare upper byte of the final transmit half-word is dropped, and the final receive half-word has a zero upper byte. Clearing the master DMA enable stops all requests and restarts the byte and half-word counters. Bytes already queued for transmit are kept and can still be taken by the shifter. The shifter's bit-order setting changes only which bit of the current byte goes out first. It never changes the order in which bytes are taken. Two one-cycle flags report a transmit underflow and a receive overflow.

Top module: `spi_dma_packer`

## Requirements
- R1: While dma_en_i is 0, tx_dma_req_o and rx_dma_req_o are both 0.
- R2: tx_dma_req_o is 1 exactly when dma_en_i and tx_req_en_i are 1, the transmit queue (TX_DEPTH half-words) has a free slot, and fewer than ceil(N/2) half-words have been accepted since dma_en_i was last 0. An accepted half-word is one with tx_dma_ack_i high while tx_dma_req_o is high. Here N is byte_cnt_i.
- R3: Each accepted half-word is presented on tx_byte_o as bits [7:0] first, then bits [15:8]. A byte advances when tx_take_i is high while tx_valid_o is high.
- R4: For odd N, only bits [7:0] of the final half-word are delivered. tx_valid_o falls after that byte when nothing else is queued.
- R5: tx_first_bit_o is tx_byte_o[0] when lsb_first_i is 1 and tx_byte_o[7] when it is 0. The byte sequence on tx_byte_o does not depend on lsb_first_i.
- R6: Received bytes are paired in order, with the first into [7:0] and the second into [15:8]. Each completed half-word is queued (RX_DEPTH entries). rx_dma_req_o is 1 while the queue is not empty and dma_en_i and rx_req_en_i are 1. rx_dma_data_o shows the oldest entry, and rx_dma_ack_i removes it.
- R7: For odd N, the final received byte forms a half-word with bits [15:8] equal to 0.
- R8: Received bytes beyond the first N since dma_en_i was last 0 are ignored, as are bytes received while dma_en_i is 0.
- R9: If a half-word completes while the receive queue is full and rx_flush_i is 0, that half-word is dropped and rx_overflow_o is 1 in the following cycle. When rx_flush_i is 1, received data is discarded and is never queued or flagged.
- R10: tx_take_i high while tx_valid_o is 0 makes tx_underflow_o 1 in the following cycle.
- R11: Half-words already queued for transmit stay deliverable after dma_en_i is cleared. After a new enable, fetching starts again from zero.
- R12: During reset, both request outputs, tx_valid_o and both flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | Master DMA enable; when low, clears the counters |
| tx_req_en_i | input | 1 | Allows transmit DMA requests |
| rx_req_en_i | input | 1 | Allows receive DMA requests |
| rx_flush_i | input | 1 | Discards received data |
| lsb_first_i | input | 1 | Serial bit order: 1 means LSB first |
| byte_cnt_i | input | CNT_W | Transfer length N in bytes |
| tx_dma_req_o | output | 1 | Transmit half-word request |
| tx_dma_ack_i | input | 1 | DMA supplies tx_dma_data_i this cycle |
| tx_dma_data_i | input | 16 | Transmit half-word |
| tx_byte_o | output | 8 | Current byte for the shifter |
| tx_first_bit_o | output | 1 | First serial bit of tx_byte_o |
| tx_valid_o | output | 1 | tx_byte_o holds a byte |
| tx_take_i | input | 1 | Shifter consumes the current byte |
| tx_underflow_o | output | 1 | Take with no byte available (one cycle) |
| rx_byte_i | input | 8 | Received byte |
| rx_byte_valid_i | input | 1 | rx_byte_i is valid this cycle |
| rx_dma_req_o | output | 1 | Receive half-word request |
| rx_dma_ack_i | input | 1 | DMA takes rx_dma_data_o this cycle |
| rx_dma_data_o | output | 16 | Oldest packed half-word |
| rx_overflow_o | output | 1 | Half-word dropped because the queue was full (one cycle) |

## Verification
The request outputs and tx_byte_o are combinational from registered state. The bench therefore samples them at the falling edge and drives the matching ack or take in that same half-cycle. An acked half-word reaches tx_valid_o at the next falling edge. A completing received byte raises rx_dma_req_o one cycle after it is driven. Each flag is checked at the falling edge one cycle after the stimulus that causes it. The sweeps run every byte count from 1 to 7 in both directions, with the bit order alternating.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;

  typedef struct packed {
    logic              single; // only low byte is payload
    logic [HALF_W-1:0] data;
  } tx_entry_t;
endpackage

// File: rtl/pk_fifo.sv
module pk_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assert_no_push_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |-> !push_i);
  assert_no_pop_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/tx_splitter.sv
module tx_splitter
  import spi_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              req_en_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              ack_i,
  input  logic [HALF_W-1:0] data_i,
  output logic              req_o,
  input  logic              full_i,
  input  logic              empty_i,
  input  tx_entry_t         head_i,
  output logic              push_o,
  output tx_entry_t         push_entry_o,
  output logic              pop_o,
  input  logic              take_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic              underflow_o
);
  logic [CNT_W:0] hw_cnt_q, need_hw;
  logic           hi_phase_q;

  assign need_hw = ({1'b0, byte_cnt_i} + 1'b1) >> 1;
  assign req_o   = dma_en_i && req_en_i && !full_i && (hw_cnt_q < need_hw);
  assign push_o  = req_o && ack_i;
  assign push_entry_o.data   = data_i;
  assign push_entry_o.single = byte_cnt_i[0] && ((hw_cnt_q + 1'b1) == need_hw);

  assign valid_o = !empty_i;
  assign byte_o  = hi_phase_q ? head_i.data[15:8] : head_i.data[7:0];
  assign pop_o   = take_i && valid_o && (hi_phase_q || head_i.single);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_cnt_q    <= '0;
      hi_phase_q  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      if (!dma_en_i)   hw_cnt_q <= '0;
      else if (push_o) hw_cnt_q <= hw_cnt_q + 1'b1;
      if (take_i && valid_o) hi_phase_q <= !(hi_phase_q || head_i.single);
      underflow_o <= take_i && !valid_o;
    end
  end

  // padded half-word yields one byte, then moves on
  assert_pad_dropped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && valid_o && !hi_phase_q && head_i.single) |=> !hi_phase_q);
  assert_fetch_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_i |-> (hw_cnt_q <= need_hw));
endmodule

// File: rtl/rx_packer.sv
module rx_packer
  import spi_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              flush_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [HALF_W-1:0] push_data_o,
  output logic              overflow_o
);
  logic [CNT_W-1:0]  rx_cnt_q;
  logic              have_lo_q;
  logic [BYTE_W-1:0] lo_q;
  logic              accept, last, complete;

  assign accept   = dma_en_i && byte_valid_i && (rx_cnt_q < byte_cnt_i);
  assign last     = ({1'b0, rx_cnt_q} + 1'b1) == {1'b0, byte_cnt_i};
  assign complete = accept && (have_lo_q || last);
  assign push_data_o = have_lo_q ? {byte_i, lo_q} : {8'h00, byte_i};
  assign push_o   = complete && !flush_i && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt_q   <= '0;
      have_lo_q  <= 1'b0;
      lo_q       <= '0;
      overflow_o <= 1'b0;
    end else begin
      overflow_o <= complete && !flush_i && full_i;
      if (!dma_en_i) begin
        rx_cnt_q  <= '0;
        have_lo_q <= 1'b0;
      end else if (accept) begin
        rx_cnt_q  <= rx_cnt_q + 1'b1;
        have_lo_q <= !complete;
        lo_q      <= byte_i;
      end
    end
  end

  assert_overflow_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(full_i) && !$past(flush_i)));
  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(byte_cnt_i) && dma_en_i && $past(dma_en_i) |-> (rx_cnt_q <= byte_cnt_i));
endmodule

// File: rtl/spi_dma_packer.sv
module spi_dma_packer
  import spi_dma_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TX_DEPTH = 2,
  parameter int unsigned RX_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              tx_req_en_i,
  input  logic              rx_req_en_i,
  input  logic              rx_flush_i,
  input  logic              lsb_first_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic              tx_dma_req_o,
  input  logic              tx_dma_ack_i,
  input  logic [HALF_W-1:0] tx_dma_data_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_first_bit_o,
  output logic              tx_valid_o,
  input  logic              tx_take_i,
  output logic              tx_underflow_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_byte_valid_i,
  output logic              rx_dma_req_o,
  input  logic              rx_dma_ack_i,
  output logic [HALF_W-1:0] rx_dma_data_o,
  output logic              rx_overflow_o
);
  localparam int unsigned TX_EW = $bits(tx_entry_t);

  tx_entry_t tx_push_entry, tx_head;
  logic      tx_push, tx_pop, tx_full, tx_empty;
  logic [TX_EW-1:0] tx_head_raw;

  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [HALF_W-1:0] rx_push_data;

  assign tx_head = tx_entry_t'(tx_head_raw);

  pk_fifo #(.W(TX_EW), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .push_data_i(TX_EW'(tx_push_entry)),
    .pop_i(tx_pop), .head_o(tx_head_raw),
    .empty_o(tx_empty), .full_o(tx_full)
  );

  tx_splitter #(.CNT_W(CNT_W)) i_tx_split (
    .clk_i, .rst_ni,
    .dma_en_i, .req_en_i(tx_req_en_i), .byte_cnt_i,
    .ack_i(tx_dma_ack_i), .data_i(tx_dma_data_i), .req_o(tx_dma_req_o),
    .full_i(tx_full), .empty_i(tx_empty), .head_i(tx_head),
    .push_o(tx_push), .push_entry_o(tx_push_entry), .pop_o(tx_pop),
    .take_i(tx_take_i), .byte_o(tx_byte_o), .valid_o(tx_valid_o),
    .underflow_o(tx_underflow_o)
  );

  assign tx_first_bit_o = lsb_first_i ? tx_byte_o[0] : tx_byte_o[BYTE_W-1];

  rx_packer #(.CNT_W(CNT_W)) i_rx_pack (
    .clk_i, .rst_ni,
    .dma_en_i, .flush_i(rx_flush_i), .byte_cnt_i,
    .byte_i(rx_byte_i), .byte_valid_i(rx_byte_valid_i),
    .full_i(rx_full), .push_o(rx_push), .push_data_o(rx_push_data),
    .overflow_o(rx_overflow_o)
  );

  assign rx_dma_req_o = dma_en_i && rx_req_en_i && !rx_empty;
  assign rx_pop       = rx_dma_req_o && rx_dma_ack_i;

  pk_fifo #(.W(HALF_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .push_data_i(rx_push_data),
    .pop_i(rx_pop), .head_o(rx_dma_data_o),
    .empty_o(rx_empty), .full_o(rx_full)
  );

  assert_no_req_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> (!tx_dma_req_o && !rx_dma_req_o));
  assert_underflow_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_take_i && !tx_valid_o) |=> tx_underflow_o);
  assert_ack_fills_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dma_req_o && tx_dma_ack_i) |=> tx_valid_o);
  assert_rx_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && dma_en_i && rx_req_en_i) |=> (rx_dma_req_o || !$past(dma_en_i) || !dma_en_i || !rx_req_en_i));
endmodule

// File: tb/test_spi_dma_packer.sv
module test_spi_dma_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dma_en_i = 0, tx_req_en_i = 0, rx_req_en_i = 0, rx_flush_i = 0, lsb_first_i = 0;
  logic [7:0]  byte_cnt_i = '0;
  logic        tx_dma_ack_i = 0, tx_take_i = 0, rx_byte_valid_i = 0, rx_dma_ack_i = 0;
  logic [15:0] tx_dma_data_i = '0;
  logic [7:0]  rx_byte_i = '0;
  logic        tx_dma_req_o, tx_first_bit_o, tx_valid_o, tx_underflow_o;
  logic        rx_dma_req_o, rx_overflow_o;
  logic [7:0]  tx_byte_o;
  logic [15:0] rx_dma_data_o;

  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  spi_dma_packer i_spi_dma_packer (.*);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_b(input int n, input int j);
    return 8'(n * 16 + j + 3);
  endfunction
  function automatic logic [7:0] rx_b(input int j);
    return 8'(8'hA0 + j * 7);
  endfunction

  task automatic idle_all();
    tx_dma_ack_i = 0; tx_take_i = 0; rx_byte_valid_i = 0; rx_dma_ack_i = 0;
  endtask

  task automatic disable_cycles();
    @(negedge clk_i); idle_all(); dma_en_i = 0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx, k, got, ovf;
    repeat (2) @(negedge clk_i);
    // R12 reset state
    check(!tx_dma_req_o && !rx_dma_req_o && !tx_valid_o && !tx_underflow_o && !rx_overflow_o,
          "R12", {tx_dma_req_o, rx_dma_req_o, tx_valid_o, tx_underflow_o, rx_overflow_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // transmit sweep over N = 1..7 (R2 R3 R4 R5)
    for (int n = 1; n <= 7; n++) begin
      disable_cycles();
      byte_cnt_i = 8'(n); lsb_first_i = n[0]; tx_req_en_i = 1; rx_req_en_i = 0; dma_en_i = 1;
      idx = 0; k = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk_i);
        if (tx_valid_o && idx < n) begin
          check(tx_byte_o == tx_b(n, idx), "R3", tx_byte_o, tx_b(n, idx));
          check(tx_first_bit_o == (lsb_first_i ? tx_byte_o[0] : tx_byte_o[7]), "R5",
                tx_first_bit_o, lsb_first_i ? tx_byte_o[0] : tx_byte_o[7]);
          tx_take_i = 1; idx++;
        end else tx_take_i = 0;
        if (tx_dma_req_o) begin
          tx_dma_ack_i = 1; tx_dma_data_i = {tx_b(n, 2*k+1), tx_b(n, 2*k)}; k++;
        end else tx_dma_ack_i = 0;
      end
      idle_all();
      @(negedge clk_i);
      check(k == (n + 1) / 2, "R2", k, (n + 1) / 2);
      check(idx == n, "R3", idx, n);
      check(!tx_valid_o, "R4", tx_valid_o, 0);
      check(!tx_underflow_o, "R10", tx_underflow_o, 0);
    end

    // receive sweep over N = 1..7 with two extra bytes (R6 R7 R8)
    for (int n = 1; n <= 7; n++) begin
      disable_cycles();
      byte_cnt_i = 8'(n); tx_req_en_i = 0; rx_req_en_i = 1; rx_flush_i = 0; dma_en_i = 1;
      idx = 0; got = 0; ovf = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk_i);
        if (rx_overflow_o) ovf++;
        if (rx_dma_req_o) begin
          if (2*got + 1 < n)
            check(rx_dma_data_o == {rx_b(2*got+1), rx_b(2*got)}, "R6", rx_dma_data_o,
                  {rx_b(2*got+1), rx_b(2*got)});
          else
            check(rx_dma_data_o == {8'h00, rx_b(2*got)}, "R7", rx_dma_data_o, {8'h00, rx_b(2*got)});
          got++; rx_dma_ack_i = 1;
        end else rx_dma_ack_i = 0;
        if (idx < n + 2) begin rx_byte_i = rx_b(idx); rx_byte_valid_i = 1; idx++; end
        else rx_byte_valid_i = 0;
      end
      check(got == (n + 1) / 2, "R8", got, (n + 1) / 2);
      check(ovf == 0, "R9", ovf, 0);
    end

    // R8: bytes while disabled are ignored
    disable_cycles();
    byte_cnt_i = 8'd4;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i); rx_byte_i = rx_b(c); rx_byte_valid_i = 1;
    end
    @(negedge clk_i); rx_byte_valid_i = 0; dma_en_i = 1;
    @(negedge clk_i);
    check(!rx_dma_req_o, "R8", rx_dma_req_o, 0);

    // R9 overflow: 8 bytes, requests off, queue of 2
    disable_cycles();
    byte_cnt_i = 8'd8; rx_req_en_i = 0; rx_flush_i = 0; dma_en_i = 1; ovf = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i);
      if (rx_overflow_o) ovf++;
      if (c < 8) begin rx_byte_i = rx_b(c); rx_byte_valid_i = 1; end else rx_byte_valid_i = 0;
    end
    check(ovf == 2, "R9", ovf, 2);
    check(!rx_dma_req_o, "R6", rx_dma_req_o, 0);
    rx_req_en_i = 1;
    @(negedge clk_i);
    check(rx_dma_req_o && rx_dma_data_o == {rx_b(1), rx_b(0)}, "R9", rx_dma_data_o, {rx_b(1), rx_b(0)});
    rx_dma_ack_i = 1;
    @(negedge clk_i);
    check(rx_dma_req_o && rx_dma_data_o == {rx_b(3), rx_b(2)}, "R9", rx_dma_data_o, {rx_b(3), rx_b(2)});
    @(negedge clk_i); rx_dma_ack_i = 0;
    check(!rx_dma_req_o, "R9", rx_dma_req_o, 0);

    // R9 flush: nothing queued, no overflow
    disable_cycles();
    rx_flush_i = 1; dma_en_i = 1; ovf = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i);
      if (rx_overflow_o || rx_dma_req_o) ovf++;
      if (c < 8) begin rx_byte_i = rx_b(c); rx_byte_valid_i = 1; end else rx_byte_valid_i = 0;
    end
    check(ovf == 0, "R9", ovf, 0);
    rx_flush_i = 0;

    // R10 underflow with only receive requests enabled
    disable_cycles();
    rx_req_en_i = 1; tx_req_en_i = 0; dma_en_i = 1;
    @(negedge clk_i);
    check(!tx_dma_req_o, "R2", tx_dma_req_o, 0);
    tx_take_i = 1;
    @(negedge clk_i); tx_take_i = 0;
    check(tx_underflow_o, "R10", tx_underflow_o, 1);
    @(negedge clk_i);
    check(!tx_underflow_o, "R10", tx_underflow_o, 0);

    // R11: queued data survives disable; counters restart
    disable_cycles();
    byte_cnt_i = 8'd8; tx_req_en_i = 1; dma_en_i = 1; k = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk_i);
      if (tx_dma_req_o) begin tx_dma_ack_i = 1; tx_dma_data_i = {tx_b(9, 2*k+1), tx_b(9, 2*k)}; k++; end
      else tx_dma_ack_i = 0;
    end
    tx_dma_ack_i = 0;
    check(k == 2, "R2", k, 2);
    check(!tx_dma_req_o, "R2", tx_dma_req_o, 0);
    dma_en_i = 0;
    @(negedge clk_i);
    check(!tx_dma_req_o && !rx_dma_req_o, "R1", {tx_dma_req_o, rx_dma_req_o}, 0);
    for (int j = 0; j < 4; j++) begin
      check(tx_valid_o && tx_byte_o == tx_b(9, j), "R11", tx_byte_o, tx_b(9, j));
      tx_take_i = 1;
      @(negedge clk_i);
    end
    tx_take_i = 0;
    check(!tx_valid_o, "R11", tx_valid_o, 0);
    byte_cnt_i = 8'd2; dma_en_i = 1;
    @(negedge clk_i);
    check(tx_dma_req_o, "R11", tx_dma_req_o, 1);
    tx_dma_ack_i = 1; tx_dma_data_i = 16'h5AA5;
    @(negedge clk_i); tx_dma_ack_i = 0;
    check(!tx_dma_req_o, "R2", tx_dma_req_o, 0);
    check(tx_valid_o && tx_byte_o == 8'hA5, "R3", tx_byte_o, 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule